// File: doc/BRIEF.md
# SD Host SDMA Boundary Engine

This block is the single-operation DMA mover of an SD host controller. Software programs a system memory address, a block length, a block count and a transfer mode through a small register bus. A write to the mode register then launches a run of blocks. Depending on the direction bit, bytes move either from the card-side receive stream into memory or from memory out to the card-side transmit stream. Each access moves one byte, and the memory address advances by one per byte.

The engine stops at every programmable power-of-two address boundary and raises a boundary status bit. Software resumes the run by writing the address register again, with any value. The engine raises a done status after the last block and an error status when a memory access is answered with an error. The status bits are cleared by writing ones, and a prioritised cause code summarises what is pending.

Register offsets on `reg_addr`:

| Offset | Contents |
|---|---|
| 0 | address |
| 1 | block length [11:0] and boundary code [14:12] |
| 2 | block count [15:0] |
| 3 | mode |
| 4 | host control, DMA select at [4:3] |
| 5 | status |

Top module: `sdma_engine`

## Requirements
- R1: After reset, status reads 0, `busy`, `irq`, `irq_code`, `mem_req`, `rx_ready` and `tx_valid` are all 0.
- R2: A write to offset 3 with bit 0 set launches a run only when the engine is idle, the DMA select at offset 4 bits [4:3] is 00, and the block length is nonzero. Any other select value (01, 10 or 11) or a zero length leaves the engine idle.
- R3: Mode bit 4 = 1 moves bytes from the receive stream into memory using memory writes. Mode bit 4 = 0 reads memory and sends the bytes on the transmit stream.
- R4: Bytes are accessed at consecutive addresses, one per memory access, starting from the programmed address. A memory request holds its address until it is acknowledged.
- R5: With mode bit 1 set, the count at offset 2 drops by one per finished block. With mode bit 5 clear, exactly one block moves. With bits 5 and 1 both set, the number of blocks equals the count. With bit 5 set and bit 1 clear, blocks move until an error and the count is left unchanged.
- R6: The boundary size is 4096 << code (code at offset 1 bits [14:12]). When the next address is a multiple of that size and the run is not finished, the engine pauses and sets status bit 1. While paused, offset 0 reads back the next address.
- R7: A write to offset 0 while paused resumes the run from the written address.
- R8: After the last block, status bit 0 is set and `busy` falls. If the run ends exactly on a boundary, no pause is taken.
- R9: A memory acknowledge that carries `mem_err` aborts the run and sets status bit 2.
- R10: Writing 1 to a status bit at offset 5 clears that bit. Writing 0 to a bit leaves it unchanged.
- R11: `irq` is high while any status bit is set. `irq_code` is 3 if the error bit is set, otherwise 2 if the boundary bit is set, otherwise 1 if the done bit is set, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| rx_valid | input | 1 | Receive stream byte available |
| rx_data | input | 8 | Receive stream byte |
| rx_ready | output | 1 | Engine accepts a receive byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit side accepts the byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with acknowledge |
| mem_ack | input | 1 | Access acknowledge |
| mem_err | input | 1 | Error qualifier on acknowledge |
| busy | output | 1 | A run is in progress, including while paused |
| irq | output | 1 | Any status bit set |
| irq_code | output | 2 | Highest-priority pending cause |

## Verification
The properties assume that the memory side acknowledges only a request that is raised, with `mem_err` meaningful only together with `mem_ack`. They also assume that software performs one register write per cycle. The bench memory model answers exactly one cycle after each request and never acknowledges unprompted. The stream models hold `rx_valid` and `tx_ready` high, and every register access is a single-cycle strobe driven at the falling edge. Runs are placed so that memory read regions never overlap regions that earlier runs wrote.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    MV_IDLE,
    MV_GET,
    MV_MEM,
    MV_PUT,
    MV_PAUSE
  } mv_state_t;

  localparam logic [2:0] OFS_ADDR  = 3'd0;
  localparam logic [2:0] OFS_SIZE  = 3'd1;
  localparam logic [2:0] OFS_COUNT = 3'd2;
  localparam logic [2:0] OFS_MODE  = 3'd3;
  localparam logic [2:0] OFS_HOST  = 3'd4;
  localparam logic [2:0] OFS_STAT  = 3'd5;

  localparam int MODE_DMA   = 0;
  localparam int MODE_CNTEN = 1;
  localparam int MODE_RD    = 4;
  localparam int MODE_MULTI = 5;

  localparam int SEL_LO = 3;

  localparam int STAT_DONE  = 0;
  localparam int STAT_BOUND = 1;
  localparam int STAT_ERR   = 2;
endpackage

// File: rtl/sdma_bound.sv
module sdma_bound #(
  parameter int BASE_LOG2 = 12,
  parameter int CODE_W    = 3,
  localparam int NCODE    = 1 << CODE_W,
  localparam int LOW_W    = BASE_LOG2 + NCODE - 1
) (
  input  logic [LOW_W-1:0]  addr_low,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  logic [NCODE-1:0] hit_vec;

  // one zero-detector per boundary size, selected by the code
  for (genvar g = 0; g < NCODE; g++) begin : g_code
    assign hit_vec[g] = (addr_low[BASE_LOG2+g-1:0] == '0);
  end

  assign hit = hit_vec[code];
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16,
  parameter int CODE_W = 3,
  localparam int SW    = LEN_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [SW-1:0]     wdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              ev_done,
  input  logic              ev_bound,
  input  logic              ev_err,
  output logic [LEN_W-1:0]  blk_len,
  output logic [CODE_W-1:0] bcode,
  output logic [5:0]        mode_q,
  output logic [7:0]        host_q,
  output logic [2:0]        stat_q,
  output logic              start,
  output logic              launch_rd,
  output logic              addr_we,
  output logic              cnt_we
);
  logic [SW-1:0] size_q, size_d;
  logic [5:0]    mode_d;
  logic [7:0]    host_d;
  logic [2:0]    stat_d, clr;
  logic          wr_size, wr_mode, wr_host, wr_stat;
  logic          need_cnt;

  assign wr_size = reg_we && (reg_addr == OFS_SIZE) && !busy;
  assign wr_mode = reg_we && (reg_addr == OFS_MODE) && !busy;
  assign wr_host = reg_we && (reg_addr == OFS_HOST) && !busy;
  assign wr_stat = reg_we && (reg_addr == OFS_STAT);
  assign addr_we = reg_we && (reg_addr == OFS_ADDR);
  assign cnt_we  = reg_we && (reg_addr == OFS_COUNT);

  assign blk_len = size_q[LEN_W-1:0];
  assign bcode   = size_q[SW-1:LEN_W];

  assign need_cnt  = wdata[MODE_MULTI] && wdata[MODE_CNTEN];
  assign start     = wr_mode && wdata[MODE_DMA]
                     && (host_q[SEL_LO+1:SEL_LO] == 2'b00)
                     && (blk_len != '0)
                     && !(need_cnt && (cnt_q == '0));
  assign launch_rd = wdata[MODE_RD];

  always_comb begin
    size_d = size_q;
    mode_d = mode_q;
    host_d = host_q;
    if (wr_size) size_d = wdata;
    if (wr_mode) mode_d = wdata[5:0];
    if (wr_host) host_d = wdata[7:0];
    clr    = wr_stat ? wdata[2:0] : 3'b000;
    // a new event wins over a clear in the same cycle
    stat_d = (stat_q & ~clr) | {ev_err, ev_bound, ev_done};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      mode_q <= '0;
      host_q <= '0;
      stat_q <= '0;
    end else begin
      size_q <= size_d;
      mode_q <= mode_d;
      host_q <= host_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/sdma_mover.sv
module sdma_mover
  import sdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 16,
  parameter int BASE_LOG2 = 12,
  parameter int CODE_W    = 3,
  localparam int LOW_W    = BASE_LOG2 + (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              launch_rd,
  input  logic              dir_rd,
  input  logic              multi,
  input  logic              cnt_en,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [CODE_W-1:0] bcode,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              busy,
  output logic              paused,
  output logic              ev_done,
  output logic              ev_bound,
  output logic              ev_err
);
  mv_state_t         st_q, st_d, st_first;
  logic [ADDR_W-1:0] addr_d, addr_inc;
  logic [CNT_W-1:0]  cnt_d;
  logic [LEN_W-1:0]  bytes_q, bytes_d;
  logic [LEN_W:0]    bytes_inc;
  logic [7:0]        data_q, data_d;
  logic              byte_done, blk_end, last, bound_hit;

  assign addr_inc  = addr_q + ADDR_W'(1);
  assign bytes_inc = {1'b0, bytes_q} + (LEN_W+1)'(1);
  assign blk_end   = (bytes_inc == {1'b0, blk_len});
  assign last      = blk_end && (!multi || (cnt_en && (cnt_q == CNT_W'(1))));
  assign st_first  = dir_rd ? MV_GET : MV_MEM;

  sdma_bound #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) u_bound (
    .addr_low (addr_inc[LOW_W-1:0]),
    .code     (bcode),
    .hit      (bound_hit)
  );

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    bytes_d   = bytes_q;
    data_d    = data_q;
    byte_done = 1'b0;
    ev_done   = 1'b0;
    ev_bound  = 1'b0;
    ev_err    = 1'b0;
    unique case (st_q)
      MV_IDLE: begin
        if (start) begin
          bytes_d = '0;
          st_d    = launch_rd ? MV_GET : MV_MEM;
        end else begin
          if (addr_we) addr_d = addr_wdata;
          if (cnt_we)  cnt_d  = cnt_wdata;
        end
      end
      MV_GET: begin
        if (rx_valid) begin
          data_d = rx_data;
          st_d   = MV_MEM;
        end
      end
      MV_MEM: begin
        if (mem_ack) begin
          if (mem_err) begin
            ev_err = 1'b1;
            st_d   = MV_IDLE;
          end else if (dir_rd) begin
            byte_done = 1'b1;
          end else begin
            data_d = mem_rdata;
            st_d   = MV_PUT;
          end
        end
      end
      MV_PUT: begin
        if (tx_ready) byte_done = 1'b1;
      end
      MV_PAUSE: begin
        if (addr_we) begin
          addr_d = addr_wdata;
          st_d   = st_first;
        end
      end
      default: st_d = MV_IDLE;
    endcase

    if (byte_done) begin
      addr_d = addr_inc;
      if (blk_end) begin
        bytes_d = '0;
        if (cnt_en) cnt_d = cnt_q - CNT_W'(1);
      end else begin
        bytes_d = bytes_inc[LEN_W-1:0];
      end
      if (last) begin
        ev_done = 1'b1;
        st_d    = MV_IDLE;
      end else if (bound_hit) begin
        ev_bound = 1'b1;
        st_d     = MV_PAUSE;
      end else begin
        st_d = st_first;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= MV_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      bytes_q <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      bytes_q <= bytes_d;
      data_q  <= data_d;
    end
  end

  assign rx_ready  = (st_q == MV_GET);
  assign mem_req   = (st_q == MV_MEM);
  assign mem_we    = dir_rd;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign tx_valid  = (st_q == MV_PUT);
  assign tx_data   = data_q;
  assign busy      = (st_q != MV_IDLE);
  assign paused    = (st_q == MV_PAUSE);
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 16,
  parameter int BASE_LOG2 = 12,
  parameter int CODE_W    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  output logic        busy,
  output logic        irq,
  output logic [1:0]  irq_code
);
  localparam int SW = LEN_W + CODE_W;

  logic [1:0]        rst_sync;
  logic              rst_s_n;
  logic [ADDR_W-1:0] addr_q, mem_addr_i;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  blk_len;
  logic [CODE_W-1:0] bcode;
  logic [5:0]        mode_q;
  logic [7:0]        host_q;
  logic [2:0]        stat_q;
  logic              start, launch_rd, addr_we, cnt_we;
  logic              eng_paused, ev_done, ev_bound, ev_err;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  sdma_regs #(.LEN_W(LEN_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wdata     (reg_wdata[SW-1:0]),
    .busy      (busy),
    .cnt_q     (cnt_q),
    .ev_done   (ev_done),
    .ev_bound  (ev_bound),
    .ev_err    (ev_err),
    .blk_len   (blk_len),
    .bcode     (bcode),
    .mode_q    (mode_q),
    .host_q    (host_q),
    .stat_q    (stat_q),
    .start     (start),
    .launch_rd (launch_rd),
    .addr_we   (addr_we),
    .cnt_we    (cnt_we)
  );

  sdma_mover #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)
  ) u_mover (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .start      (start),
    .launch_rd  (launch_rd),
    .dir_rd     (mode_q[MODE_RD]),
    .multi      (mode_q[MODE_MULTI]),
    .cnt_en     (mode_q[MODE_CNTEN]),
    .blk_len    (blk_len),
    .bcode      (bcode),
    .addr_we    (addr_we),
    .addr_wdata (reg_wdata[ADDR_W-1:0]),
    .cnt_we     (cnt_we),
    .cnt_wdata  (reg_wdata[CNT_W-1:0]),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr_i),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .addr_q     (addr_q),
    .cnt_q      (cnt_q),
    .busy       (busy),
    .paused     (eng_paused),
    .ev_done    (ev_done),
    .ev_bound   (ev_bound),
    .ev_err     (ev_err)
  );

  always_comb begin
    mem_addr = '0;
    mem_addr[ADDR_W-1:0] = mem_addr_i;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_ADDR:  reg_rdata[ADDR_W-1:0] = addr_q;
      OFS_SIZE: begin
        reg_rdata[LEN_W-1:0]     = blk_len;
        reg_rdata[LEN_W+:CODE_W] = bcode;
      end
      OFS_COUNT: reg_rdata[CNT_W-1:0] = cnt_q;
      OFS_MODE:  reg_rdata[5:0] = mode_q;
      OFS_HOST:  reg_rdata[7:0] = host_q;
      OFS_STAT:  reg_rdata[2:0] = stat_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = |stat_q;

  always_comb begin
    if (stat_q[STAT_ERR])        irq_code = 2'd3;
    else if (stat_q[STAT_BOUND]) irq_code = 2'd2;
    else if (stat_q[STAT_DONE])  irq_code = 2'd1;
    else                         irq_code = 2'd0;
  end
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk (
  input logic        clk,
  input logic        rst_s_n,
  input logic        busy,
  input logic        paused,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_err,
  input logic [31:0] mem_addr,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic [2:0]  stat
);
  // R4: only one side of the byte path is active in any cycle
  p_one_phase_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({mem_req, rx_ready, tx_valid}));

  // R4: a pending request keeps its address until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R6: entering pause comes with the boundary status
  p_pause_flag_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(paused) |-> stat[1]);

  // R8: done status appears only once the engine is idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(stat[0]) |-> !busy);

  // R8, R9: a run never ends without done or error recorded
  p_stop_reason_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(busy) |-> (stat[0] || stat[2]));

  // R9: an errored acknowledge aborts and flags
  p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && mem_ack && mem_err) |=> (!busy && stat[2]));
endmodule

bind sdma_engine sdma_engine_chk u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .busy     (busy),
  .paused   (eng_paused),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_err  (mem_err),
  .mem_addr (mem_addr),
  .rx_ready (rx_ready),
  .tx_valid (tx_valid),
  .stat     (stat_q)
);

// File: tb/sim_sdma_engine.sv
module sim_sdma_engine;
  logic        clk, rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0]  rx_data, tx_data;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, irq;
  logic [1:0]  irq_code;

  int checks = 0;
  int failures = 0;
  int rx_idx = 0;
  int tx_idx = 0;
  logic err_inject = 1'b0;
  logic [7:0] mem [0:16383];
  logic [7:0] tx_log [0:255];

  sdma_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .busy(busy), .irq(irq), .irq_code(irq_code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat_c(input int i);
    return 8'(i * 13 + 5);
  endfunction
  function automatic logic [7:0] pat_m(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign rx_data = pat_c(rx_idx);

  // card-side models
  always @(posedge clk) begin
    if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
    if (tx_valid && tx_ready) begin
      tx_log[8'(tx_idx)] <= tx_data;
      tx_idx <= tx_idx + 1;
    end
  end

  // memory model: answers one cycle after a request
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_err   <= err_inject;
      mem_rdata <= pat_m(mem_addr);
      if (mem_we && !err_inject) mem[mem_addr[13:0]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_addr = off;
    #1;
    d = reg_rdata;
  endtask

  task automatic poll_stat(input logic [2:0] mask, output logic [31:0] s);
    s = '0;
    for (int i = 0; i < 4000; i++) begin
      reg_read(3'd5, s);
      if ((s[2:0] & mask) != 3'b000) break;
    end
  endtask

  typedef struct packed {
    logic        rd;
    logic        multi;
    logic        cen;
    logic [11:0] len;
    logic [15:0] cnt;
    logic [31:0] addr;
    logic [2:0]  code;
    logic [3:0]  pauses;
    logic [31:0] fin;
    logic [15:0] fcnt;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 1'b1, 12'd8,  16'd1, 32'h0000_0100, 3'd0, 4'd0, 32'h0000_0108, 16'd0},
    '{1'b1, 1'b1, 1'b1, 12'd4,  16'd3, 32'h0000_0FF8, 3'd0, 4'd1, 32'h0000_1004, 16'd0},
    '{1'b0, 1'b1, 1'b1, 12'd16, 16'd2, 32'h0000_0200, 3'd0, 4'd0, 32'h0000_0220, 16'd0},
    '{1'b1, 1'b1, 1'b1, 12'd8,  16'd2, 32'h0000_1FF0, 3'd1, 4'd0, 32'h0000_2000, 16'd0},
    '{1'b0, 1'b1, 1'b1, 12'd4,  16'd4, 32'h0000_2FFC, 3'd0, 4'd1, 32'h0000_300C, 16'd0},
    '{1'b1, 1'b0, 1'b1, 12'd4,  16'd5, 32'h0000_0300, 3'd0, 4'd0, 32'h0000_0304, 16'd4},
    '{1'b1, 1'b1, 1'b1, 12'd4,  16'd2, 32'h0000_3FFC, 3'd7, 4'd0, 32'h0000_4004, 16'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, a;
    int base, bad, total, np;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 1'b1; tx_ready = 1'b1;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    reg_read(3'd5, d);
    check(d == 0, "R1 status", d, 0);
    check({busy, irq, irq_code, mem_req, rx_ready, tx_valid} == 7'd0, "R1 outputs",
          {busy, irq, irq_code, mem_req, rx_ready, tx_valid}, 0);

    // R2 reserved DMA select leaves engine idle
    reg_write(3'd4, 32'h10);
    reg_write(3'd1, 32'd4);
    reg_write(3'd2, 32'd1);
    reg_write(3'd0, 32'h500);
    base = rx_idx;
    reg_write(3'd3, 32'h13);
    repeat (5) @(negedge clk);
    check(!busy && rx_idx == base, "R2 select 10 ignored", {31'd0, busy}, 0);
    reg_read(3'd4, d);
    check(d[4:3] == 2'b10, "R2 select readback", d, 32'h10);
    reg_write(3'd4, 32'h0);
    reg_write(3'd1, 32'd0);
    reg_write(3'd3, 32'h13);
    repeat (5) @(negedge clk);
    check(!busy, "R2 zero length ignored", {31'd0, busy}, 0);

    // vector table: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      reg_write(3'd1, {17'd0, VEC[v].code, VEC[v].len});
      reg_write(3'd2, {16'd0, VEC[v].cnt});
      reg_write(3'd0, VEC[v].addr);
      base = VEC[v].rd ? rx_idx : tx_idx;
      reg_write(3'd3, {26'd0, VEC[v].multi, VEC[v].rd, 2'b00, VEC[v].cen, 1'b1});
      np = 0;
      for (int it = 0; it < 8; it++) begin
        poll_stat(3'b011, d);
        if (d[1]) begin
          np++;
          reg_read(3'd0, a);
          check(a == (((VEC[v].addr >> (12 + VEC[v].code)) + 1) << (12 + VEC[v].code)),
                "R6 paused address readback", a,
                ((VEC[v].addr >> (12 + VEC[v].code)) + 1) << (12 + VEC[v].code));
          reg_write(3'd5, 32'h2);
          reg_write(3'd0, a);
        end else break;
      end
      check(d[0] == 1'b1 && !busy, "R8 done raised", d, 1);
      check(np == int'(VEC[v].pauses), "R6 pause count", np, {28'd0, VEC[v].pauses});
      reg_read(3'd0, a);
      check(a == VEC[v].fin, "R4 final address", a, VEC[v].fin);
      reg_read(3'd2, d);
      check(d[15:0] == VEC[v].fcnt, "R5 remaining count", d, {16'd0, VEC[v].fcnt});
      total = VEC[v].multi ? int'(VEC[v].cnt) * int'(VEC[v].len) : int'(VEC[v].len);
      bad = 0;
      for (int k = 0; k < total; k++) begin
        logic [31:0] ka;
        ka = VEC[v].addr + 32'(k);
        if (VEC[v].rd) begin
          if (mem[ka[13:0]] !== pat_c(base + k)) bad++;
        end else begin
          if (tx_log[8'(base + k)] !== pat_m(ka)) bad++;
        end
      end
      check(bad == 0, "R3 data moved", bad, 0);
      reg_write(3'd5, 32'h1);
      check(!irq, "R10 done cleared", {31'd0, irq}, 0);
    end

    // R5 multi without count enable runs on; R9 error aborts
    reg_write(3'd1, 32'd4);
    reg_write(3'd2, 32'd7);
    reg_write(3'd0, 32'h600);
    reg_write(3'd3, 32'h31);
    repeat (40) @(negedge clk);
    reg_read(3'd2, d);
    check(busy && d == 32'd7, "R5 unlimited keeps count", d, 7);
    err_inject = 1'b1;
    poll_stat(3'b100, d);
    err_inject = 1'b0;
    check(d[2:0] == 3'b100 && !busy, "R9 error status", d, 4);
    check(irq_code == 2'd3, "R11 code error", {30'd0, irq_code}, 3);

    // R11 error beats done; R10 write-one-to-clear
    reg_write(3'd1, 32'd2);
    reg_write(3'd2, 32'd1);
    reg_write(3'd0, 32'h700);
    reg_write(3'd3, 32'h13);
    poll_stat(3'b001, d);
    check(d[2:0] == 3'b101, "R8 done with error pending", d, 5);
    check(irq_code == 2'd3, "R11 error over done", {30'd0, irq_code}, 3);
    reg_write(3'd5, 32'h4);
    reg_read(3'd5, d);
    check(d[2:0] == 3'b001 && irq_code == 2'd1, "R10 clear error only", d, 1);
    reg_write(3'd5, 32'h0);
    reg_read(3'd5, d);
    check(d[2:0] == 3'b001, "R10 zero write no effect", d, 1);
    reg_write(3'd5, 32'h1);
    check(!irq && irq_code == 2'd0, "R11 idle code", {30'd0, irq_code}, 0);

    // R7 resume from a new address; R11 boundary over done
    reg_write(3'd1, 32'd4);
    reg_write(3'd2, 32'd2);
    reg_write(3'd0, 32'h4FFC);
    base = rx_idx;
    reg_write(3'd3, 32'h33);
    poll_stat(3'b010, d);
    check(busy && d[2:0] == 3'b010, "R6 pause at boundary", d, 2);
    reg_write(3'd0, 32'h5800);
    poll_stat(3'b001, d);
    check(d[2:0] == 3'b011, "R8 done with boundary pending", d, 3);
    check(irq_code == 2'd2, "R11 boundary over done", {30'd0, irq_code}, 2);
    reg_read(3'd0, a);
    check(a == 32'h5804, "R7 resumed address", a, 32'h5804);
    bad = 0;
    for (int k = 0; k < 4; k++) begin
      if (mem[14'h0FFC + 14'(k)] !== pat_c(base + k)) bad++;
      if (mem[14'h1800 + 14'(k)] !== pat_c(base + 4 + k)) bad++;
    end
    check(bad == 0, "R7 data split across resume", bad, 0);
    reg_write(3'd5, 32'h3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule